// File: doc/BRIEF.md
# Timer-Counter PWM Waveform Channel

This block is one timer-counter channel that produces two pulse-width-modulated outputs, A and B, from one shared up-counter. A prescaler turns the system clock into count ticks. The tick rate is the system clock divided by 2, 8, 32 or 128, or it comes from an external slow-clock strobe of about 32 kHz that has already been brought into the system clock domain. The counter returns to zero after it reaches the period register. Both outputs therefore share one period, and each output has its own duty compare register.

Neither output has a fixed high/low rule. Each output carries three programmable 2-bit actions: one for its own duty compare, one for the period compare, and one for the software trigger. Normal polarity sets the output on the period compare and clears it on the duty compare. Inverted polarity swaps these two actions. A duty of zero, or a duty equal to the period, is handled by programming no compare actions, so the output holds the level that the software trigger set. Software writes the mode word and the compare registers, then issues a command that starts or stops the count clock together with a software trigger, which applies the new settings.

Top module: `tc_pwm_channel`

## Requirements
- R1: After reset both outputs are low, the count is 0 and the count clock is disabled, so the count stays at 0 while clocks run.
- R2: Clock-select field mode[2:0] values 0, 1, 2 and 3 select division by 2, 8, 32 and 128. After an enabling software trigger, the count reads k once N*k system clocks have passed (N is the divisor).
- R3: Clock-select value 4 advances the count once for each cycle in which `slow_tick` is high, and never without it.
- R4: The count wraps from the period value to 0, so one period lasts period+1 ticks.
- R5: A tick taken while the count equals the A duty value applies the A duty action (mode[5:4]) to A. A tick taken while the count equals the B duty value applies the B duty action (mode[11:10]) to B.
- R6: A tick taken while the count equals the period value applies the period action to each output: mode[7:6] for A and mode[13:12] for B.
- R7: Action codes: 00 none, 01 set, 10 clear, 11 toggle.
- R8: When an output's duty compare and the period compare occur on the same tick, the period action is applied.
- R9: A software trigger clears the count and the prescaler and applies each output's trigger action (mode[9:8] for A, mode[15:14] for B). It overrides any compare event in that cycle.
- R10: Command word bits: bit 0 enables the clock, bit 1 disables it, bit 2 issues a software trigger. Disable wins over enable. A disabled clock freezes the count, and the outputs hold their level.
- R11: An output with no compare actions, as used for duty 0 or duty equal to the period, keeps its trigger level throughout every period.
- R12: Write addresses: 0 mode, 1 A duty, 2 B duty, 3 period, 4 command. Compare register writes take effect at the next edge. Addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow-clock strobe, one system cycle wide, already synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data (mode uses bits 15:0) |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| count | output | CNT_W | Current counter value |

## Verification
Every register write and command takes effect on the rising edge that captures it. The count after an enabling trigger reads k at exactly N*k edges later. An output changes on the same edge as the tick at which the count leaves the matching compare value, so its level is a pure function of the expected count. The bench drives and samples on falling edges and counts edges from the capturing edge of the last command. It compares the count and both outputs against that formula every cycle. For the trigger-versus-compare and period-versus-duty collisions, the stimulus is placed on the exact edge where both events coincide.

// File: rtl/tcpwm_pkg.sv
package tcpwm_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // clock select
  localparam int SEL_W   = 3;
  localparam int NUM_DIV = 4;
  localparam logic [SEL_W-1:0] SEL_SLOW = SEL_W'(NUM_DIV);
  localparam int PRE_W   = 2 * NUM_DIV - 1;

  // mode word action layout
  localparam int NUM_OUT    = 2;
  localparam int ACT_BASE   = 4;
  localparam int ACT_STRIDE = 6;
  localparam int MODE_W     = ACT_BASE + ACT_STRIDE * NUM_OUT;
  localparam int SLOT_OWN   = 0;
  localparam int SLOT_PER   = 1;
  localparam int SLOT_TRG   = 2;

  // command bits
  localparam int CMD_EN  = 0;
  localparam int CMD_DIS = 1;
  localparam int CMD_TRG = 2;

  // addresses
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_DA   = 3'd1;
  localparam logic [ADDR_W-1:0] A_DB   = 3'd2;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd4;

  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  // log2 of the divisor for an internal clock select (1,3,5,7)
  function automatic int div_log2(logic [SEL_W-1:0] sel);
    return 2 * int'(sel) + 1;
  endfunction

  function automatic act_e act_field(logic [MODE_W-1:0] mode, int idx, int slot);
    return act_e'(mode[ACT_BASE + ACT_STRIDE * idx + 2 * slot +: 2]);
  endfunction

endpackage

// File: rtl/tcpwm_prescaler.sv
module tcpwm_prescaler
  import tcpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  input  logic             slow_tick,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             src;

  always_ff @(posedge clk) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    mask = '0;
    for (int b = 0; b < PRE_W; b++)
      if (b < div_log2(sel)) mask[b] = 1'b1;
  end

  always_comb begin
    if (sel < SEL_SLOW)       src = ((pre_q & mask) == mask);
    else if (sel == SEL_SLOW) src = slow_tick;
    else                      src = 1'b0;
    tick = en & ~clr & src;
  end

  // internal divisors are at least 2, so ticks never come back to back
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel < SEL_SLOW) |=> (!tick || !$stable(sel)));

endmodule

// File: rtl/tcpwm_counter.sv
module tcpwm_counter #(
  parameter int CNT_W = 16,
  parameter int NCMP  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       clr,
  input  logic [CNT_W-1:0]           per,
  input  logic [NCMP-1:0][CNT_W-1:0] duty,
  output logic [CNT_W-1:0]           cnt,
  output logic                       per_hit,
  output logic [NCMP-1:0]            duty_hit
);

  assign per_hit = tick & (cnt == per);

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign duty_hit[i] = tick & (cnt == duty[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (per_hit) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && cnt == per) |=> (cnt == '0));

endmodule

// File: rtl/tcpwm_out_unit.sv
module tcpwm_out_unit
  import tcpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trg,
  input  logic per_hit,
  input  logic own_hit,
  input  act_e act_own,
  input  act_e act_per,
  input  act_e act_trg,
  output logic out_q
);

  logic nxt;

  // priority: software trigger, then period compare, then duty compare
  always_comb begin
    if (trg)          nxt = apply_act(act_trg, out_q);
    else if (per_hit) nxt = apply_act(act_per, out_q);
    else if (own_hit) nxt = apply_act(act_own, out_q);
    else              nxt = out_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= nxt;
  end

  a_r8_period_wins_set: assert property (@(posedge clk) disable iff (!rst_n)
    (per_hit && !trg && act_per == ACT_SET) |=> out_q);

  a_r9_trigger_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (trg && act_trg == ACT_CLR) |=> !out_q);

  a_r5_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!trg && !per_hit && !own_hit) |=> $stable(out_q));

endmodule

// File: rtl/tc_pwm_channel.sv
module tc_pwm_channel
  import tcpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              out_a,
  output logic              out_b,
  output logic [CNT_W-1:0]  count
);

  logic [MODE_W-1:0]                mode_q;
  logic [NUM_OUT-1:0][CNT_W-1:0]    duty_q;
  logic [CNT_W-1:0]                 per_q;
  logic                             clk_on;
  logic                             cmd_wr;
  logic                             trg;
  logic                             tick;
  logic                             per_hit;
  logic [NUM_OUT-1:0]               duty_hit;
  logic [NUM_OUT-1:0]               outs;

  assign cmd_wr = wr_en && (wr_addr == A_CMD);
  assign trg    = cmd_wr && wr_data[CMD_TRG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
      clk_on <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE: mode_q    <= wr_data[MODE_W-1:0];
        A_DA:   duty_q[0] <= wr_data;
        A_DB:   duty_q[1] <= wr_data;
        A_PER:  per_q     <= wr_data;
        A_CMD: begin
          if (wr_data[CMD_DIS])     clk_on <= 1'b0;
          else if (wr_data[CMD_EN]) clk_on <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  tcpwm_prescaler u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (clk_on),
    .clr       (trg),
    .sel       (mode_q[SEL_W-1:0]),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  tcpwm_counter #(.CNT_W(CNT_W), .NCMP(NUM_OUT)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clr      (trg),
    .per      (per_q),
    .duty     (duty_q),
    .cnt      (count),
    .per_hit  (per_hit),
    .duty_hit (duty_hit)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    tcpwm_out_unit u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .trg     (trg),
      .per_hit (per_hit),
      .own_hit (duty_hit[i]),
      .act_own (act_field(mode_q, i, SLOT_OWN)),
      .act_per (act_field(mode_q, i, SLOT_PER)),
      .act_trg (act_field(mode_q, i, SLOT_TRG)),
      .out_q   (outs[i])
    );
  end

  assign out_a = outs[0];
  assign out_b = outs[1];

  a_r9_trigger_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    trg |=> (count == '0));

  a_r10_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_on && !trg) |=> $stable(count));

  a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_on && !trg) |=> ($stable(out_a) && $stable(out_b)));

endmodule

// File: tb/tc_pwm_channel_bench.sv
`timescale 1ns/1ps
module tc_pwm_channel_bench;

  localparam logic [1:0] NN = 2'd0, ST = 2'd1, CL = 2'd2, TG = 2'd3;
  localparam logic [15:0] GO = 16'h5, STOP_TRG = 16'h6, DIS = 16'h2, BOTH_TRG = 16'h7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        out_a, out_b;
  logic [15:0] count;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tc_pwm_channel u_tc_pwm_channel (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_a(out_a), .out_b(out_b),
    .count(count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; captured at the next rising edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mk_mode(input logic [2:0] sel,
      input logic [1:0] ao, input logic [1:0] ap, input logic [1:0] at,
      input logic [1:0] bo, input logic [1:0] bp, input logic [1:0] bt);
    return {bt, bp, bo, at, ap, ao, 1'b0, sel};
  endfunction

  task automatic t_reset();
    chk("R1 out_a", 32'(out_a), 0);
    chk("R1 out_b", 32'(out_b), 0);
    chk("R1 count", 32'(count), 0);
    repeat (10) @(negedge clk);
    chk("R1 count idle", 32'(count), 0);
  endtask

  task automatic t_pwm_basic();
    wr(3'd1, 3); wr(3'd2, 6); wr(3'd3, 9);
    wr(3'd0, mk_mode(3'd0, CL, ST, ST, ST, CL, CL));
    wr(3'd4, GO);
    for (int t = 0; t < 60; t++) begin
      int c;
      c = (t / 2) % 10;
      chk("R4 count", 32'(count), 32'(c));
      chk("R5 R6 out_a normal", 32'(out_a), 32'(c <= 3));
      chk("R5 R6 out_b inverted", 32'(out_b), 32'(c > 6));
      @(negedge clk);
    end
  endtask

  task automatic t_prescale();
    wr(3'd3, 16'd1000);
    for (int s = 1; s < 4; s++) begin
      int n;
      n = 1 << (2 * s + 1);
      wr(3'd0, mk_mode(3'(s), NN, NN, CL, NN, NN, CL));
      wr(3'd4, GO);
      for (int t = 0; t < n * 4; t++) begin
        chk("R2 count rate", 32'(count), 32'(t / n));
        @(negedge clk);
      end
    end
  endtask

  task automatic t_slow();
    wr(3'd3, 16'd1000);
    wr(3'd0, mk_mode(3'd4, NN, NN, CL, NN, NN, CL));
    wr(3'd4, GO);
    repeat (5) @(negedge clk);
    chk("R3 no strobe", 32'(count), 0);
    for (int k = 1; k <= 4; k++) begin
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      chk("R3 strobe step", 32'(count), 32'(k));
      repeat (3) @(negedge clk);
      chk("R3 strobe hold", 32'(count), 32'(k));
    end
  endtask

  task automatic t_disable();
    wr(3'd1, 3); wr(3'd2, 6); wr(3'd3, 9);
    wr(3'd0, mk_mode(3'd0, CL, ST, ST, ST, CL, CL));
    wr(3'd4, GO);
    repeat (15) @(negedge clk);
    wr(3'd4, DIS);
    for (int t = 0; t < 20; t++) begin
      chk("R10 frozen count", 32'(count), 8);
      chk("R10 hold a", 32'(out_a), 0);
      chk("R10 hold b", 32'(out_b), 1);
      @(negedge clk);
    end
    wr(3'd4, STOP_TRG);
    for (int t = 0; t < 20; t++) begin
      chk("R9 R10 stop count", 32'(count), 0);
      chk("R9 R10 stop a", 32'(out_a), 1);
      chk("R9 R10 stop b", 32'(out_b), 0);
      @(negedge clk);
    end
    wr(3'd4, BOTH_TRG);
    repeat (10) @(negedge clk);
    chk("R10 disable wins", 32'(count), 0);
  endtask

  task automatic t_flat();
    wr(3'd1, 0); wr(3'd2, 9); wr(3'd3, 9);
    wr(3'd0, mk_mode(3'd0, NN, NN, CL, NN, NN, ST));
    wr(3'd4, GO);
    for (int t = 0; t < 40; t++) begin
      chk("R11 duty zero low", 32'(out_a), 0);
      chk("R11 duty full high", 32'(out_b), 1);
      @(negedge clk);
    end
  endtask

  task automatic t_priority();
    wr(3'd1, 5); wr(3'd3, 5);
    wr(3'd0, mk_mode(3'd0, CL, ST, CL, NN, NN, CL));
    wr(3'd4, GO);
    for (int t = 0; t < 40; t++) begin
      chk("R8 period wins", 32'(out_a), 32'((t / 2) >= 6));
      chk("R8 b idle", 32'(out_b), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_toggle();
    wr(3'd3, 4);
    wr(3'd0, mk_mode(3'd0, NN, TG, CL, NN, NN, ST));
    wr(3'd4, GO);
    for (int t = 0; t < 50; t++) begin
      chk("R7 toggle", 32'(out_a), 32'(((t / 2) / 5) % 2));
      chk("R7 none holds", 32'(out_b), 1);
      @(negedge clk);
    end
  endtask

  task automatic t_trigger_override();
    wr(3'd1, 1); wr(3'd3, 3);
    wr(3'd0, mk_mode(3'd0, CL, ST, CL, NN, NN, CL));
    wr(3'd4, GO);
    for (int t = 0; t < 7; t++) begin
      chk("R9 pre count", 32'(count), 32'(t / 2));
      chk("R9 pre a", 32'(out_a), 0);
      @(negedge clk);
    end
    wr(3'd4, GO);  // lands on the edge of the period compare
    chk("R9 override a", 32'(out_a), 0);
    chk("R9 override count", 32'(count), 0);
    for (int t = 0; t < 8; t++) begin
      chk("R9 restart count", 32'(count), 32'(t / 2));
      chk("R9 restart a", 32'(out_a), 0);
      @(negedge clk);
    end
    chk("R9 period again", 32'(out_a), 1);
  endtask

  task automatic t_address();
    wr(3'd1, 3); wr(3'd2, 6); wr(3'd3, 9);
    wr(3'd0, mk_mode(3'd0, CL, ST, ST, ST, CL, CL));
    wr(3'd4, GO);
    for (int t = 0; t < 60; t++) begin
      int c;
      c = (t / 2) % 10;
      chk("R12 count", 32'(count), 32'(c));
      chk("R12 out_a", 32'(out_a), 32'(c <= ((t >= 21) ? 7 : 3)));
      chk("R12 out_b", 32'(out_b), 32'(c > 6));
      wr_en = 1'b0;
      if (t == 10) begin wr_en = 1'b1; wr_addr = 3'd5; wr_data = 16'hFFFF; end
      if (t == 12) begin wr_en = 1'b1; wr_addr = 3'd7; wr_data = 16'h0002; end
      if (t == 14) begin wr_en = 1'b1; wr_addr = 3'd6; wr_data = 16'h0000; end
      if (t == 20) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'd7; end
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pwm_basic();
    t_prescale();
    t_slow();
    t_disable();
    t_flat();
    t_priority();
    t_toggle();
    t_trigger_override();
    t_address();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule